// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the input pins of a general-purpose I/O controller and turns selected pin activity into interrupts. Every pin is configured independently, through three configuration registers, to fire on a rising edge, a falling edge, either edge, a high level or a low level. Pin inputs are first brought into the clock domain by a two-stage synchronizer. Detected events are then latched into a status register, and a single interrupt line is raised whenever an unmasked pin has a pending event.

Software reaches the block through a simple single-cycle register port. Writes take effect at the clock edge. Reads return data in the same cycle from a combinational multiplexer. Pending events are acknowledged in bulk: reading the status register returns every pending bit and clears them all at that edge. There is no per-pin acknowledge. An event that is detected in the same cycle as the clearing read is kept rather than dropped.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the trigger type, trigger value, any-edge, mask and status registers all read zero, and irqOut is low.
- R2: With type bit 0, value bit 0 and any-edge bit 0, a high-to-low transition on the pin sets its status bit, and a low-to-high transition does not.
- R3: With type bit 0, value bit 1 and any-edge bit 0, a low-to-high transition sets the pin's status bit, and a high-to-low transition does not.
- R4: With type bit 0 and any-edge bit 1, a transition in either direction sets the pin's status bit, whatever the value bit holds.
- R5: With type bit 1, the status bit is set on every cycle in which the synchronized pin equals the value bit (1 = high, 0 = low). The any-edge bit has no effect in this mode.
- R6: Reading address 4 (status) returns all pending bits and clears them all at that clock edge. Without such a read, a status bit never clears. Writes to address 4 are ignored.
- R7: An event that is detected in the same cycle as a status read is not lost. It is set in the status register after the clear.
- R8: A level-triggered pin whose condition still holds is pending again immediately after a clearing read.
- R9: irqOut is the OR of status AND mask (mask bit 1 = enabled). Masked pins still record status.
- R10: Register addresses are 0 = type, 1 = value, 2 = any-edge, 3 = mask, 4 = status. Written configuration reads back unchanged. A pin change applied before clock edge k shows in status after edge k+2 (two synchronizer flops plus one previous-value flop feed the status register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | NUM_PINS | Asynchronous pin inputs |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe (clears status when addressing status) |
| regWrData | input | NUM_PINS | Write data |
| regRdData | output | NUM_PINS | Read data, combinational from regAddr |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is a new edge that lands exactly in the cycle of a clearing status read. In that case the clear and the set meet on the same flop. The bench changes a pin on a falling clock edge, waits one cycle, and then issues the read so that the synchronized edge reaches the detector during the read cycle. It then checks that the first read returns the bit clear and the second read finds it set. Repeated re-assertion of a level-triggered pin after a clear is checked by two reads in a row while the level is held.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_TYPE   = 3'd0,
    ADDR_VALUE  = 3'd1,
    ADDR_ANY    = 3'd2,
    ADDR_MASK   = 3'd3,
    ADDR_STATUS = 3'd4
  } regAddrE;

  typedef struct packed {
    logic    wrType;
    logic    wrValue;
    logic    wrAny;
    logic    wrMask;
    logic    rdStatus;
    logic    rdValid;
    regAddrE rdSel;
  } strobeT;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output strobeT            strb
);
  always_comb begin
    strb          = '0;
    strb.rdSel    = regAddrE'(regAddr);
    strb.rdValid  = 1'b0;
    unique case (regAddr)
      ADDR_TYPE:   begin strb.wrType  = regWrEn; strb.rdValid = 1'b1; end
      ADDR_VALUE:  begin strb.wrValue = regWrEn; strb.rdValid = 1'b1; end
      ADDR_ANY:    begin strb.wrAny   = regWrEn; strb.rdValid = 1'b1; end
      ADDR_MASK:   begin strb.wrMask  = regWrEn; strb.rdValid = 1'b1; end
      ADDR_STATUS: begin strb.rdStatus = regRdEn; strb.rdValid = 1'b1; end
      default:     strb.rdValid = 1'b0;
    endcase
  end

  // R10: at most one configuration register is written per cycle
  a_r10_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrType, strb.wrValue, strb.wrAny, strb.wrMask}));

  // R6: a status clear is only ever requested by a read
  a_r6_clear_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStatus |-> regRdEn);
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strb,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  output logic                irqOut
);
  logic [NUM_PINS-1:0] typeReg, valueReg, anyReg, maskReg, statusReg;
  logic [NUM_PINS-1:0] pinSync, pinPrev, hitVec;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeReg  <= '0;
      valueReg <= '0;
      anyReg   <= '0;
      maskReg  <= '0;
      pinPrev  <= '0;
    end else begin
      if (strb.wrType)  typeReg  <= wrData;
      if (strb.wrValue) valueReg <= wrData;
      if (strb.wrAny)   anyReg   <= wrData;
      if (strb.wrMask)  maskReg  <= wrData;
      pinPrev <= pinSync;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic isRise, isFall, edgeHit, levelHit;
    always_comb begin
      isRise   = pinSync[p] & ~pinPrev[p];
      isFall   = ~pinSync[p] & pinPrev[p];
      levelHit = (pinSync[p] == valueReg[p]);
      if (anyReg[p])        edgeHit = isRise | isFall;
      else if (valueReg[p]) edgeHit = isRise;
      else                  edgeHit = isFall;
      hitVec[p] = typeReg[p] ? levelHit : edgeHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              statusReg <= '0;
    else if (strb.rdStatus) statusReg <= hitVec;
    else                    statusReg <= statusReg | hitVec;
  end

  assign irqOut = |(statusReg & maskReg);

  always_comb begin
    rdData = '0;
    if (strb.rdValid) begin
      unique case (strb.rdSel)
        ADDR_TYPE:   rdData = typeReg;
        ADDR_VALUE:  rdData = valueReg;
        ADDR_ANY:    rdData = anyReg;
        ADDR_MASK:   rdData = maskReg;
        ADDR_STATUS: rdData = statusReg;
        default:     rdData = '0;
      endcase
    end
  end

  logic [NUM_PINS-1:0] riseOnly, fallOnly;
  assign riseOnly = ~typeReg & valueReg & ~anyReg & pinSync & ~pinPrev;
  assign fallOnly = ~typeReg & ~valueReg & ~anyReg & ~pinSync & pinPrev;

  // R6: pending bits persist until a status read
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStatus |=> ((statusReg & $past(statusReg)) == $past(statusReg)));

  // R7: the clearing read keeps the events detected in its own cycle
  a_r7_keep_on_read: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStatus |=> (statusReg == $past(hitVec)));

  // R3: a qualified rising edge lands in status
  a_r3_rise_lands: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusReg & $past(riseOnly)) == $past(riseOnly)));

  // R2: a qualified falling edge lands in status
  a_r2_fall_lands: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusReg & $past(fallOnly)) == $past(fallOnly)));

  // R9: with nothing pending the interrupt stays low
  a_r9_quiet_irq: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg == '0) |-> !irqOut);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [NUM_PINS-1:0] regWrData,
  output logic [NUM_PINS-1:0] regRdData,
  output logic                irqOut
);
  strobeT strb;

  gpio_irq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strb    (strb)
  );

  gpio_irq_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .pinIn  (pinIn),
    .wrData (regWrData),
    .rdData (regRdData),
    .irqOut (irqOut)
  );
endmodule

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinIn = '0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  gpio_irq_detect u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [31:0] cfgType, cfgVal, cfgAny, pinsA, pinsB, cfgMask;
  } vecT;

  localparam vecT VECS [0:5] = '{
    '{32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'hFFFF_FFFF},
    '{32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h3C3C_3C3C, 32'h0000_00FF},
    '{32'h0, 32'h00FF_00FF, 32'hFFFF_0000, 32'h1234_5678, 32'h8765_4321, 32'hFFFF_FFFF},
    '{32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h0F0F_F0F0, 32'h0, 32'hFFFF_0000, 32'h0},
    '{32'h0000_FFFF, 32'h0F0F_0F0F, 32'h00FF_00FF, 32'h5555_5555, 32'h3333_3333, 32'h0000_FFFF},
    '{32'h0, 32'h0F0F_0F0F, 32'hF0F0_0000, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'hFFFF_FFFF}
  };

  // Expected status from R2..R5 and R8: level pins count both held levels
  function automatic logic [31:0] expStatus(vecT x);
    logic [31:0] edgeHit, lvlHit;
    edgeHit = (x.cfgAny & (x.pinsA ^ x.pinsB))
            | (~x.cfgAny & x.cfgVal & ~x.pinsA & x.pinsB)
            | (~x.cfgAny & ~x.cfgVal & x.pinsA & ~x.pinsB);
    lvlHit  = ~(x.cfgVal ^ x.pinsA) | ~(x.cfgVal ^ x.pinsB);
    return (x.cfgType & lvlHit) | (~x.cfgType & edgeHit);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] addr, input logic [31:0] data);
    @(negedge clk);
    regAddr = addr; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] addr, output logic [31:0] data);
    @(negedge clk);
    regAddr = addr; regRdEn = 1'b1;
    #1 data = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      readReg(3'(a), rd);
      check("R1 reset reg", rd, 32'h0);
    end
    check("R1 reset irq", {31'h0, irqOut}, 32'h0);

    // R6: writes to status are ignored
    writeReg(3'd4, 32'hFFFF_FFFF);
    readReg(3'd4, rd);
    check("R6 status write ignored", rd, 32'h0);

    // R10: configuration readback
    writeReg(3'd1, 32'hCAFE_F00D); readReg(3'd1, rd); check("R10 value readback", rd, 32'hCAFE_F00D);
    writeReg(3'd2, 32'h1357_9BDF); readReg(3'd2, rd); check("R10 any readback", rd, 32'h1357_9BDF);
    writeReg(3'd3, 32'h0246_8ACE); readReg(3'd3, rd); check("R10 mask readback", rd, 32'h0246_8ACE);
    writeReg(3'd0, 32'hDEAD_BEEF); readReg(3'd0, rd); check("R10 type readback", rd, 32'hDEAD_BEEF);

    // R2..R5, R9: vector table
    for (int i = 0; i < 6; i++) begin
      logic [31:0] exp;
      exp = expStatus(VECS[i]);
      writeReg(3'd0, VECS[i].cfgType);
      writeReg(3'd1, VECS[i].cfgVal);
      writeReg(3'd2, VECS[i].cfgAny);
      writeReg(3'd3, VECS[i].cfgMask);
      pinIn = VECS[i].pinsA;
      repeat (4) @(negedge clk);
      readReg(3'd4, rd);
      pinIn = VECS[i].pinsB;
      repeat (4) @(negedge clk);
      check("R9 irq vector", {31'h0, irqOut}, {31'h0, |(exp & VECS[i].cfgMask)});
      readReg(3'd4, rd);
      check("R2 R3 R4 R5 status vector", rd, exp);
    end

    // R7: edge detected in the cycle of the clearing read
    writeReg(3'd0, 32'h0);
    writeReg(3'd1, 32'hFFFF_FFFF);
    writeReg(3'd2, 32'h0);
    writeReg(3'd3, 32'h0);
    pinIn = 32'h0;
    repeat (4) @(negedge clk);
    readReg(3'd4, rd);
    pinIn = 32'h1;
    @(negedge clk);
    readReg(3'd4, rd);
    check("R7 read in edge cycle", rd, 32'h0);
    readReg(3'd4, rd);
    check("R7 edge kept after clear", rd, 32'h1);

    // R8: high level on pin 0 re-pends after a clear
    writeReg(3'd0, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    readReg(3'd4, rd);
    check("R8 level pending", rd, 32'h1);
    readReg(3'd4, rd);
    check("R8 level re-pends", rd, 32'h1);

    // R9: mask gating while status stays recorded
    @(negedge clk);
    check("R9 masked irq low", {31'h0, irqOut}, 32'h0);
    writeReg(3'd3, 32'h1);
    #1 check("R9 unmasked irq high", {31'h0, irqOut}, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule